// File: doc/BRIEF.md
# Fracturable 36x36 multiplier

This block multiplies two unsigned 36-bit operands into a 72-bit product. A 2-bit configuration value can also split it into two or four independent narrower multipliers. These narrower multipliers share the same operand and product pins. In the two-way split, each half of each operand is multiplied by its partner half, and the result fills its own half of the product. In the four-way split, the same happens with quarter-width operand lanes and quarter-width product fields.

The configuration value is static: it is set once and then held. The datapath has no clock. The product follows the operands combinationally, so it is valid within the same cycle in which the operands change.

Internally, one array of sixteen lane-by-lane partial products feeds a single weighted adder. The mode decides which partial products are kept. In a split mode, every partial product whose two lanes belong to different slices is forced to zero before the sum. No carry can pass between slices, because each slice's product fits in its own field.

Top module: `fmul36_top`

## Requirements
- R1: With `cfg_mode` = 2'b00, `prod` equals the full unsigned product `op_a * op_b` across all 72 bits.
- R2: With `cfg_mode` = 2'b10, for k = 0 and 1, `prod[36k+35:36k]` equals `op_a[18k+17:18k] * op_b[18k+17:18k]`.
- R3: With `cfg_mode` = 2'b01, for k = 0 to 3, `prod[18k+17:18k]` equals `op_a[9k+8:9k] * op_b[9k+8:9k]`.
- R4: `cfg_mode` = 2'b11 gives the same product as 2'b00. This is also the value held by the configuration after its reset, since both bits default to one.
- R5: In a split mode, operand bits outside a slice have no effect on that slice's product field. Cross-slice partial products are suppressed.
- R6: All-ones operands give 72'hFFFFFFFFE000000001 in full mode, 36'hFFFF80001 in each field of the two-way split, and 18'h3FC01 in each field of the four-way split.
- R7: The product is combinational. It reflects new operands before the next clock edge, with no register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_mode | input | 2 | Static split configuration: 00 full, 10 two-way, 01 four-way, 11 full |
| op_a | input | 36 | Unsigned multiplicand |
| op_b | input | 36 | Unsigned multiplier |
| prod | output | 72 | Product, or the concatenated slice products |

## Verification
Random operands are applied in all four configuration values. Each is compared with a behavioural model that multiplies only the operand slices the mode assigns, which catches wrong lane-to-field placement and missing cross-term masking. All-ones operands drive the widest carries and the largest values in every field, which exposes truncated fields and carries leaking between slices. Vectors that differ only in the bits outside one slice show whether that slice's field stays put. Because 11 is compared against the full-product model, a decode that treats it as a split mode is caught.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

  typedef enum logic [1:0] {
    FM_WHOLE = 2'b00,
    FM_QUAD  = 2'b01,
    FM_PAIR  = 2'b10,
    FM_SPARE = 2'b11
  } fmul_mode_e;

  // Lanes grouped into one independent multiplier for a given mode.
  function automatic int lanes_per_slice(fmul_mode_e m, int lanes);
    case (m)
      FM_QUAD: return 1;
      FM_PAIR: return lanes / 2;
      default: return lanes;
    endcase
  endfunction

endpackage

// File: rtl/fmul_mode_dec.sv
module fmul_mode_dec
  import fmul_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [1:0]             mode,
  output logic [LANES*LANES-1:0] pp_keep
);
  localparam int NPP = LANES * LANES;

  int grp;

  always_comb begin
    grp = lanes_per_slice(fmul_mode_e'(mode), LANES);
    for (int i = 0; i < LANES; i++) begin
      for (int j = 0; j < LANES; j++) begin
        pp_keep[i*LANES+j] = ((i / grp) == (j / grp));
      end
    end
  end

  int exp_cnt;
  always_comb begin
    case (mode)
      2'b01:   exp_cnt = LANES;
      2'b10:   exp_cnt = NPP / 2;
      default: exp_cnt = NPP;
    endcase
    // R5
    keep_count_chk: assert ($countones(pp_keep) == exp_cnt);
  end

  // R3
  always_comb begin
    for (int d = 0; d < LANES; d++) begin
      diag_kept_chk: assert (pp_keep[d*LANES+d]);
    end
  end

endmodule

// File: rtl/fmul_pp_array.sv
module fmul_pp_array #(
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic [LANE_W*LANES-1:0]       op_a,
  input  logic [LANE_W*LANES-1:0]       op_b,
  input  logic [LANES*LANES-1:0]        pp_keep,
  output logic [LANES*LANES*2*LANE_W-1:0] pp_flat
);
  localparam int PPW = 2 * LANE_W;

  for (genvar gi = 0; gi < LANES; gi++) begin : g_row
    for (genvar gj = 0; gj < LANES; gj++) begin : g_col
      localparam int IDX = gi * LANES + gj;
      logic [PPW-1:0] raw;
      assign raw = PPW'(op_a[gi*LANE_W +: LANE_W]) * PPW'(op_b[gj*LANE_W +: LANE_W]);
      assign pp_flat[IDX*PPW +: PPW] = pp_keep[IDX] ? raw : '0;
    end
  end

endmodule

// File: rtl/fmul_pp_sum.sv
module fmul_pp_sum #(
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic [LANES*LANES*2*LANE_W-1:0] pp_flat,
  output logic [2*LANE_W*LANES-1:0]       prod
);
  localparam int PPW    = 2 * LANE_W;
  localparam int PROD_W = 2 * LANE_W * LANES;

  logic [PROD_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < LANES; i++) begin
      for (int j = 0; j < LANES; j++) begin
        acc = acc + (PROD_W'(pp_flat[(i*LANES+j)*PPW +: PPW]) << (LANE_W * (i + j)));
      end
    end
  end

  assign prod = acc;

endmodule

// File: rtl/fmul36_top.sv
module fmul36_top #(
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic [1:0]                  cfg_mode,
  input  logic [LANE_W*LANES-1:0]     op_a,
  input  logic [LANE_W*LANES-1:0]     op_b,
  output logic [2*LANE_W*LANES-1:0]   prod
);
  localparam int OP_W   = LANE_W * LANES;
  localparam int NPP    = LANES * LANES;
  localparam int PPW    = 2 * LANE_W;
  localparam int HALF_W = OP_W / 2;

  logic [NPP-1:0]     pp_keep;
  logic [NPP*PPW-1:0] pp_flat;

  fmul_mode_dec #(.LANES(LANES)) u_dec (
    .mode    (cfg_mode),
    .pp_keep (pp_keep)
  );

  fmul_pp_array #(.LANE_W(LANE_W), .LANES(LANES)) u_arr (
    .op_a    (op_a),
    .op_b    (op_b),
    .pp_keep (pp_keep),
    .pp_flat (pp_flat)
  );

  fmul_pp_sum #(.LANE_W(LANE_W), .LANES(LANES)) u_sum (
    .pp_flat (pp_flat),
    .prod    (prod)
  );

  always_comb begin
    if (cfg_mode == 2'b01 && op_a[LANE_W-1:0] == '0) begin
      // R3
      quad_zero_lane_chk: assert (prod[PPW-1:0] == '0);
    end
    if (cfg_mode == 2'b10) begin
      // R2
      pair_upper_chk: assert (prod[2*OP_W-1:OP_W] ==
        (OP_W'(op_a[OP_W-1:HALF_W]) * OP_W'(op_b[OP_W-1:HALF_W])));
    end
    if ((cfg_mode == 2'b00 || cfg_mode == 2'b11) && op_b == '0) begin
      // R4
      whole_zero_chk: assert (prod == '0);
    end
  end

endmodule

// File: tb/fmul36_top_test.sv
module fmul36_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [1:0]  mode = 2'b11;
  logic [35:0] a = '0;
  logic [35:0] b = '0;
  logic [71:0] p;
  int vectors = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fmul36_top uut (.cfg_mode(mode), .op_a(a), .op_b(b), .prod(p));

  function automatic logic [71:0] model(logic [1:0] m, logic [35:0] x, logic [35:0] y);
    logic [71:0] r;
    r = '0;
    if (m == 2'b01) begin
      for (int k = 0; k < 4; k++) r[18*k +: 18] = 18'(x[9*k +: 9]) * 18'(y[9*k +: 9]);
    end else if (m == 2'b10) begin
      for (int k = 0; k < 2; k++) r[36*k +: 36] = 36'(x[18*k +: 18]) * 36'(y[18*k +: 18]);
    end else begin
      r = 72'(x) * 72'(y);
    end
    return r;
  endfunction

  task automatic apply_exp(input logic [1:0] m, input logic [35:0] x, input logic [35:0] y,
                           input logic [71:0] exp, input string req);
    @(posedge clk);
    #1;
    mode = m; a = x; b = y;
    @(negedge clk);
    vectors++;
    if (p !== exp) begin
      fails++;
      $display("FAIL %s mode=%b a=%h b=%h actual=%h expected=%h", req, m, x, y, p, exp);
    end
  endtask

  task automatic apply(input logic [1:0] m, input logic [35:0] x, input logic [35:0] y,
                       input string req);
    apply_exp(m, x, y, model(m, x, y), req);
  endtask

  function automatic logic [35:0] rnd36();
    return {4'($urandom), 32'($urandom)};
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL R7 watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    // R4: configuration default (all ones) gives the full product
    apply_exp(2'b11, '1, '1, 72'hFFFFFFFFE000000001, "R4");
    // R6: all-ones corners in every mode
    apply_exp(2'b00, '1, '1, 72'hFFFFFFFFE000000001, "R6");
    apply_exp(2'b10, '1, '1, {2{36'hFFFF80001}}, "R6");
    apply_exp(2'b01, '1, '1, {4{18'h3FC01}}, "R6");
    // R5: cross terms suppressed in the two-way split
    apply_exp(2'b10, {18'h3FFFF, 18'h00001}, {18'h3FFFF, 18'h00001},
              {36'hFFFF80001, 36'h1}, "R5");
    apply_exp(2'b10, {18'h00000, 18'h00001}, {18'h3FFFF, 18'h00001},
              {36'h0, 36'h1}, "R5");
    // R5: only one lane driven in the four-way split
    apply_exp(2'b01, 36'h1FF << 9, 36'hFFFFFFFFF, {18'h0, 18'h0, 18'h3FC01, 18'h0}, "R5");
    // R1: top-bit operands and single bits
    apply_exp(2'b00, 36'h800000000, 36'h800000000, 72'h400000000000000000, "R1");
    apply_exp(2'b00, 36'h000000200, 36'h000000200, 72'h40000, "R1");
    // R7: back-to-back operand changes, one per cycle
    for (int i = 0; i < 20; i++) apply(2'b00, 36'(i * 7919), 36'(i * 104729), "R7");
    for (int i = 0; i < 200; i++) apply(2'b00, rnd36(), rnd36(), "R1");
    for (int i = 0; i < 200; i++) apply(2'b10, rnd36(), rnd36(), "R2");
    for (int i = 0; i < 200; i++) apply(2'b01, rnd36(), rnd36(), "R3");
    for (int i = 0; i < 200; i++) apply(2'b11, rnd36(), rnd36(), "R4");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule